// File: doc/BRIEF.md
# Interrupt Frame Save and Restore Sequencer

This block carries out the automatic context save when an interrupt or trap is granted, and the matching restore when the handler returns. When a grant arrives, it writes a two-word frame to a 16-bit-wide stack in byte-addressed data memory. The first word holds the low 16 bits of the 23-bit program counter. The second word packs three things: the status low byte (the current priority level and five condition flags), the trap-level priority bit and the upper seven program counter bits. Once both words are written, the block takes the granted priority level and trap bit as its current priority.

A return request pops the two words in the opposite order. The block then presents the recovered program counter and flags on a one-cycle restore pulse and puts back the priority it held before the interrupt.

The stack grows toward higher addresses. A push writes at the stack pointer and then adds 2. A pop subtracts 2 first and then reads. Entry and return requests use valid/ready handshakes, and the memory side uses a valid/ready request channel plus a response strobe.

Back-pressure rules:
- A request held with valid high and ready low keeps its address, write flag and data unchanged until it is accepted.
- The response channel has no ready. The block is always waiting when a read response comes.
- Entry and return are refused while a sequence is in progress.

Top module: `isr_frame_seq`

## Requirements
- R1: After reset the stack pointer equals the parameter SP_INIT, the priority level and trap bit are 0, busy is low, no memory request is valid and entry is ready.
- R2: An entry writes the first frame word, program counter bits 15:0, at the stack pointer value present at acceptance. It writes the second frame word at that address plus 2, and the second write is issued only after the first has been accepted.
- R3: The second frame word is {old level[2:0] in bits 15:13, flags[4:0] in bits 12:8, old trap bit in bit 7, program counter bits 22:16 in bits 6:0}. "Old" means the priority held before the entry.
- R4: Each accepted memory write raises the stack pointer by 2, and each pop step lowers it by 2 before the read. A completed entry therefore leaves it 4 higher, and a completed return leaves it 4 lower.
- R5: When the second push is accepted, the current level becomes the granted level and the trap bit becomes the granted trap flag. These change at no other time except a completed return.
- R6: A return reads the second frame word at SP-2 first, then the first frame word at SP-4, where SP is the value when the return was accepted. Each read waits for its response strobe.
- R7: After the second read response arrives, restore_valid is high for exactly one cycle. restore_pc is {second word bits 6:0, first word}, restore_flags is second word bits 12:8, and the level and trap bit take second word bits 15:13 and bit 7.
- R8: While busy is high, neither ent_ready nor ret_ready is high. When both requests are valid in an idle cycle, the entry is taken and the return waits.
- R9: A memory request held while mem_req_ready is low keeps its valid, address, write flag and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | 1 | Interrupt grant request |
| ent_ready | output | 1 | Grant accepted when high with ent_valid |
| ent_level | input | 3 | Priority level of the granted interrupt |
| ent_trap | input | 1 | Grant is a trap (sets the trap priority bit) |
| ent_pc | input | 23 | Program counter to save |
| ent_flags | input | 5 | Condition flags to save |
| ret_valid | input | 1 | Return request |
| ret_ready | output | 1 | Return accepted when high with ret_valid |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Byte address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_rdata | input | 16 | Read data |
| busy | output | 1 | Push or pop sequence in progress |
| sp_o | output | 16 | Stack pointer |
| ipl_level | output | 3 | Current priority level |
| ipl_trap | output | 1 | Current trap priority bit |
| restore_valid | output | 1 | One-cycle restore pulse |
| restore_pc | output | 23 | Restored program counter |
| restore_flags | output | 5 | Restored flags |

## Verification
The assertions assume that memory raises mem_rsp_valid only once per accepted read, and only after that read has been accepted. They also assume that no return is issued on an empty stack. The bench memory model answers each accepted read exactly once, after a latency that can be set, and it drives ready through several stall patterns. The stimulus never pops more frames than it has pushed.

// File: rtl/isr_frame_pkg.sv
package isr_frame_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_POP_HI_REQ,
    ST_POP_HI_WAIT,
    ST_POP_LO_REQ,
    ST_POP_LO_WAIT
  } seq_state_e;
endpackage

// File: rtl/isr_frame_codec.sv
module isr_frame_codec #(
  parameter int WORD_W = 16,
  parameter int PC_W   = 23,
  parameter int LVL_W  = 3,
  parameter int FLG_W  = 5
) (
  input  logic [PC_W-1:0]   pk_pc,
  input  logic [FLG_W-1:0]  pk_flags,
  input  logic [LVL_W-1:0]  pk_level,
  input  logic              pk_trap,
  output logic [WORD_W-1:0] pk_lo,
  output logic [WORD_W-1:0] pk_hi,
  input  logic [WORD_W-1:0] un_lo,
  input  logic [WORD_W-1:0] un_hi,
  output logic [PC_W-1:0]   un_pc,
  output logic [FLG_W-1:0]  un_flags,
  output logic [LVL_W-1:0]  un_level,
  output logic              un_trap
);
  localparam int PCH_W = PC_W - WORD_W;
  localparam int TRAP_BIT = PCH_W;
  localparam int FLG_LSB = PCH_W + 1;
  localparam int LVL_LSB = FLG_LSB + FLG_W;

  always_comb begin
    pk_lo = pk_pc[WORD_W-1:0];
    pk_hi = {pk_level, pk_flags, pk_trap, pk_pc[PC_W-1:WORD_W]};
  end

  always_comb begin
    un_pc    = {un_hi[PCH_W-1:0], un_lo};
    un_trap  = un_hi[TRAP_BIT];
    un_flags = un_hi[FLG_LSB +: FLG_W];
    un_level = un_hi[LVL_LSB +: LVL_W];
  end

  initial begin
    a_r3_layout_fits: assert (LVL_LSB + LVL_W == WORD_W);
  end
endmodule

// File: rtl/isr_stack_ptr.sv
module isr_stack_ptr #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SP_INIT = 16'h0040,
  parameter int STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [ADDR_W-1:0] sp
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= SP_INIT;
    else if (inc) sp <= sp + STEP_V;
    else if (dec) sp <= sp - STEP_V;
  end

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec));
  a_r4_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    (inc |=> sp == $past(sp) + STEP_V));
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec |=> sp == $past(sp) - STEP_V));
endmodule

// File: rtl/isr_seq_ctrl.sv
module isr_seq_ctrl
  import isr_frame_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16,
  parameter int PC_W   = 23,
  parameter int LVL_W  = 3,
  parameter int FLG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_valid,
  output logic              ent_ready,
  input  logic [LVL_W-1:0]  ent_level,
  input  logic              ent_trap,
  input  logic [WORD_W-1:0] pk_lo,
  input  logic [WORD_W-1:0] pk_hi,
  input  logic              ret_valid,
  output logic              ret_ready,
  input  logic [ADDR_W-1:0] sp,
  output logic              sp_inc,
  output logic              sp_dec,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic [WORD_W-1:0] hi_q,
  input  logic [PC_W-1:0]   un_pc,
  input  logic [FLG_W-1:0]  un_flags,
  input  logic [LVL_W-1:0]  un_level,
  input  logic              un_trap,
  output logic              busy,
  output logic [LVL_W-1:0]  ipl_level,
  output logic              ipl_trap,
  output logic              restore_valid,
  output logic [PC_W-1:0]   restore_pc,
  output logic [FLG_W-1:0]  restore_flags
);
  seq_state_e state;
  logic [WORD_W-1:0] lo_q;
  logic [LVL_W-1:0]  new_level_q;
  logic              new_trap_q;
  logic ent_fire, ret_fire, req_fire, push_done, pop_done;

  always_comb begin
    busy          = (state != ST_IDLE);
    ent_ready     = (state == ST_IDLE);
    ret_ready     = (state == ST_IDLE) && !ent_valid;
    ent_fire      = ent_valid && ent_ready;
    ret_fire      = ret_valid && ret_ready;
    mem_req_valid = (state == ST_PUSH_LO) || (state == ST_PUSH_HI) ||
                    (state == ST_POP_HI_REQ) || (state == ST_POP_LO_REQ);
    mem_req_we    = (state == ST_PUSH_LO) || (state == ST_PUSH_HI);
    mem_req_addr  = sp;
    mem_req_wdata = (state == ST_PUSH_LO) ? lo_q : hi_q;
    req_fire      = mem_req_valid && mem_req_ready;
    push_done     = req_fire && (state == ST_PUSH_HI);
    pop_done      = mem_rsp_valid && (state == ST_POP_LO_WAIT);
    sp_inc        = req_fire && mem_req_we;
    sp_dec        = ret_fire || (mem_rsp_valid && state == ST_POP_HI_WAIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      lo_q          <= '0;
      hi_q          <= '0;
      new_level_q   <= '0;
      new_trap_q    <= 1'b0;
      ipl_level     <= '0;
      ipl_trap      <= 1'b0;
      restore_valid <= 1'b0;
      restore_pc    <= '0;
      restore_flags <= '0;
    end else begin
      restore_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ent_fire) begin
            lo_q        <= pk_lo;
            hi_q        <= pk_hi;
            new_level_q <= ent_level;
            new_trap_q  <= ent_trap;
            state       <= ST_PUSH_LO;
          end else if (ret_fire) begin
            state <= ST_POP_HI_REQ;
          end
        end
        ST_PUSH_LO: if (req_fire) state <= ST_PUSH_HI;
        ST_PUSH_HI: if (req_fire) begin
          ipl_level <= new_level_q;
          ipl_trap  <= new_trap_q;
          state     <= ST_IDLE;
        end
        ST_POP_HI_REQ: if (req_fire) state <= ST_POP_HI_WAIT;
        ST_POP_HI_WAIT: if (mem_rsp_valid) begin
          hi_q  <= mem_rsp_rdata_hold(hi_q);
          state <= ST_POP_LO_REQ;
        end
        ST_POP_LO_REQ: if (req_fire) state <= ST_POP_LO_WAIT;
        ST_POP_LO_WAIT: if (mem_rsp_valid) begin
          restore_valid <= 1'b1;
          restore_pc    <= un_pc;
          restore_flags <= un_flags;
          ipl_level     <= un_level;
          ipl_trap      <= un_trap;
          state         <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // In the first read-wait state the codec's hi input is the live response,
  // so its unpacked fields reassemble the whole word for capture.
  function automatic logic [WORD_W-1:0] mem_rsp_rdata_hold(input logic [WORD_W-1:0] unused_prev);
    logic [WORD_W-1:0] w;
    w = {un_level, un_flags, un_trap, un_pc[PC_W-1:WORD_W]};
    return w | (unused_prev & '0);
  endfunction

  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!ent_ready && !ret_ready));
  a_r8_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ret_valid && !busy) |=> (busy && $past(ent_fire)));
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid);
  a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));
  a_r9_hold_we: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_we));
  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_wdata));
  a_r5_level_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_done && !pop_done) |=> ($stable(ipl_level) && $stable(ipl_trap)));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> !restore_valid);
  a_r7_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> !busy);
endmodule

// File: rtl/isr_frame_seq.sv
module isr_frame_seq #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SP_INIT = 16'h0040,
  parameter int WORD_W = 16,
  parameter int PC_W   = 23,
  parameter int LVL_W  = 3,
  parameter int FLG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_valid,
  output logic              ent_ready,
  input  logic [LVL_W-1:0]  ent_level,
  input  logic              ent_trap,
  input  logic [PC_W-1:0]   ent_pc,
  input  logic [FLG_W-1:0]  ent_flags,
  input  logic              ret_valid,
  output logic              ret_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] sp_o,
  output logic [LVL_W-1:0]  ipl_level,
  output logic              ipl_trap,
  output logic              restore_valid,
  output logic [PC_W-1:0]   restore_pc,
  output logic [FLG_W-1:0]  restore_flags
);
  localparam int BYTES_PER_WORD = WORD_W / 8;

  logic [WORD_W-1:0] pk_lo, pk_hi, hi_q, un_hi_sel;
  logic [PC_W-1:0]   un_pc;
  logic [FLG_W-1:0]  un_flags;
  logic [LVL_W-1:0]  un_level;
  logic              un_trap, sp_inc, sp_dec, hi_wait;

  // While the high word is being awaited the live response feeds the
  // unpacker; afterwards the captured high word does.
  assign hi_wait   = busy && mem_rsp_valid && !mem_req_we && (u_ctrl.state == isr_frame_pkg::ST_POP_HI_WAIT);
  assign un_hi_sel = hi_wait ? mem_rsp_rdata : hi_q;

  isr_frame_codec #(.WORD_W(WORD_W), .PC_W(PC_W), .LVL_W(LVL_W), .FLG_W(FLG_W)) u_codec (
    .pk_pc(ent_pc), .pk_flags(ent_flags), .pk_level(ipl_level), .pk_trap(ipl_trap),
    .pk_lo(pk_lo), .pk_hi(pk_hi),
    .un_lo(mem_rsp_rdata), .un_hi(un_hi_sel),
    .un_pc(un_pc), .un_flags(un_flags), .un_level(un_level), .un_trap(un_trap)
  );

  isr_stack_ptr #(.ADDR_W(ADDR_W), .SP_INIT(SP_INIT), .STEP(BYTES_PER_WORD)) u_sp (
    .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec), .sp(sp_o)
  );

  isr_seq_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PC_W(PC_W), .LVL_W(LVL_W), .FLG_W(FLG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_level(ent_level), .ent_trap(ent_trap),
    .pk_lo(pk_lo), .pk_hi(pk_hi),
    .ret_valid(ret_valid), .ret_ready(ret_ready),
    .sp(sp_o), .sp_inc(sp_inc), .sp_dec(sp_dec),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .hi_q(hi_q),
    .un_pc(un_pc), .un_flags(un_flags), .un_level(un_level), .un_trap(un_trap),
    .busy(busy), .ipl_level(ipl_level), .ipl_trap(ipl_trap),
    .restore_valid(restore_valid), .restore_pc(restore_pc), .restore_flags(restore_flags)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!mem_req_valid && !busy && sp_o == SP_INIT));
  a_r6_reads_only_when_popping: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we) |-> busy);
endmodule

// File: tb/isr_frame_seq_bench.sv
module isr_frame_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h0040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ent_valid = 1'b0, ent_trap = 1'b0, ret_valid = 1'b0;
  logic [2:0] ent_level = '0;
  logic [22:0] ent_pc = '0;
  logic [4:0] ent_flags = '0;
  logic ent_ready, ret_ready, mem_req_valid, mem_req_we, busy, ipl_trap, restore_valid;
  logic mem_req_ready = 1'b1, mem_rsp_valid = 1'b0;
  logic [15:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata, sp_o;
  logic [2:0] ipl_level;
  logic [22:0] restore_pc;
  logic [4:0] restore_flags;

  int errors = 0, checks = 0, cyc = 0, pat = 0;
  logic [15:0] mem [64];
  logic pend = 1'b0;
  int pend_cnt = 0;
  logic [15:0] pend_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isr_frame_seq u_isr_frame_seq (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_ready(ent_ready),
    .ent_level(ent_level), .ent_trap(ent_trap), .ent_pc(ent_pc), .ent_flags(ent_flags),
    .ret_valid(ret_valid), .ret_ready(ret_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .busy(busy), .sp_o(sp_o), .ipl_level(ipl_level), .ipl_trap(ipl_trap),
    .restore_valid(restore_valid), .restore_pc(restore_pc), .restore_flags(restore_flags)
  );

  function automatic int widx(input logic [15:0] a);
    logic [15:0] d;
    d = (a - BASE) >> 1;
    return int'(d[5:0]);
  endfunction

  assign mem_rsp_rdata = pend_data;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[widx(mem_req_addr)] <= mem_req_wdata;
      else begin
        pend <= 1'b1; pend_cnt <= pat; pend_data <= mem[widx(mem_req_addr)];
      end
    end else if (pend && mem_rsp_valid) pend <= 1'b0;
    else if (pend && pend_cnt != 0) pend_cnt <= pend_cnt - 1;
  end

  always @(negedge clk) begin
    case (pat)
      0: mem_req_ready <= 1'b1;
      1: mem_req_ready <= (cyc % 2) == 0;
      2: mem_req_ready <= (cyc % 3) == 0;
      default: mem_req_ready <= (cyc % 4) != 1;
    endcase
    mem_rsp_valid <= pend && pend_cnt == 0 && !mem_rsp_valid;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_entry(input logic [2:0] lvl, input logic trp, input logic [22:0] pc, input logic [4:0] fl,
                          input logic [2:0] old_lvl, input logic old_trp, input logic [15:0] sp_before);
    logic [15:0] exp_hi;
    @(negedge clk);
    ent_valid = 1'b1; ent_level = lvl; ent_trap = trp; ent_pc = pc; ent_flags = fl;
    @(negedge clk);
    ent_valid = 1'b0;
    chk(!ent_ready && !ret_ready, "R8 busy refuses", {30'd0, ent_ready, ret_ready}, 0);
    while (busy) @(negedge clk);
    exp_hi = {old_lvl, fl, old_trp, pc[22:16]};
    chk(mem[widx(sp_before)] == pc[15:0], "R2 word0", mem[widx(sp_before)], pc[15:0]);
    chk(mem[widx(sp_before + 16'd2)] == exp_hi, "R3 word1", mem[widx(sp_before + 16'd2)], exp_hi);
    chk(sp_o == sp_before + 16'd4, "R4 sp after entry", sp_o, sp_before + 16'd4);
    chk(ipl_level == lvl && ipl_trap == trp, "R5 new priority", {ipl_level, ipl_trap}, {lvl, trp});
  endtask

  task automatic do_return(input logic [22:0] pc, input logic [4:0] fl, input logic [2:0] old_lvl,
                           input logic old_trp, input logic [15:0] sp_before);
    @(negedge clk);
    ret_valid = 1'b1;
    @(negedge clk);
    ret_valid = 1'b0;
    chk(sp_o == sp_before - 16'd2, "R6 sp predecrement", sp_o, sp_before - 16'd2);
    while (busy) @(negedge clk);
    chk(restore_valid, "R7 restore pulse", restore_valid, 1);
    chk(restore_pc == pc, "R7 pc", restore_pc, pc);
    chk(restore_flags == fl, "R7 flags", restore_flags, fl);
    chk(ipl_level == old_lvl && ipl_trap == old_trp, "R7 priority", {ipl_level, ipl_trap}, {old_lvl, old_trp});
    chk(sp_o == sp_before - 16'd4, "R6 sp after return", sp_o, sp_before - 16'd4);
    @(negedge clk);
    chk(!restore_valid, "R7 pulse width", restore_valid, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [22:0] epc [4];
    logic [4:0]  efl [4];
    logic [2:0]  elv [5];
    logic        etr [5];
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp_o == BASE, "R1 sp", sp_o, BASE);
    chk(ipl_level == 0 && !ipl_trap, "R1 priority", {ipl_level, ipl_trap}, 0);
    chk(!busy && !mem_req_valid && ent_ready, "R1 idle", {busy, mem_req_valid, ent_ready}, 3'b001);
    for (int p = 0; p < 4; p++) begin
      pat = p;
      for (int d = 1; d <= 4; d++) begin
        elv[0] = 3'd0; etr[0] = 1'b0;
        for (int k = 0; k < d; k++) begin
          epc[k] = 23'((k * 23'h1357 + d * 23'h2A001 + p * 23'h0111 + 23'h10000) ^ (p * 23'h550000));
          efl[k] = 5'((k * 7 + p + d) % 32);
          elv[k+1] = 3'(k + 1 + (p % 2));
          etr[k+1] = (k == d - 1) && (p == 3);
          do_entry(elv[k+1], etr[k+1], epc[k], efl[k], elv[k], etr[k], BASE + 16'(4 * k));
        end
        for (int k = d - 1; k >= 0; k--)
          do_return(epc[k], efl[k], elv[k], etr[k], BASE + 16'(4 * (k + 1)));
      end
    end
    // R8: entry and return both requested in an idle cycle with one frame stacked
    pat = 1;
    do_entry(3'd2, 1'b0, 23'h412345, 5'h0A, 3'd0, 1'b0, BASE);
    @(negedge clk);
    ent_valid = 1'b1; ret_valid = 1'b1; ent_level = 3'd5; ent_trap = 1'b0;
    ent_pc = 23'h0ABCDE; ent_flags = 5'h15;
    @(negedge clk);
    ent_valid = 1'b0; ret_valid = 1'b0;
    while (busy) @(negedge clk);
    chk(sp_o == BASE + 16'd8, "R8 entry wins", sp_o, BASE + 16'd8);
    chk(!restore_valid && ipl_level == 3'd5, "R8 no return taken", {restore_valid, ipl_level}, 4'd5);
    do_return(23'h0ABCDE, 5'h15, 3'd2, 1'b0, BASE + 16'd8);
    do_return(23'h412345, 5'h0A, 3'd0, 1'b0, BASE + 16'd4);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule